// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one clamp pulse per video line for the front end of a video digitizer. It runs on the pixel clock. A pixel counter restarts on a chosen transition of the horizontal sync input. The pulse starts once the counter reaches a programmable start pixel, and it lasts a programmable number of pixels. The pulse can also be taken from an external clamp input in place of the internal generator.

The first cycle of every clamp pulse raises a one-cycle leading-edge strobe. That strobe copies a host-written pending offset value into the active offset register, so the offset applied downstream only changes at a clamp leading edge. A second strobe, raised in the same cycle, tells the black-level averaging logic to start, and it can be switched off. The configuration fields are captured into internal registers by a load strobe. The horizontal sync input and the external clamp input each pass through a two-flop synchroniser before they are used.

Top module: `line_clamp_gen`

## Requirements
- R1: After reset, `clamp_out`, `clamp_lead` and `avg_start` are low and `ofs_active` is 0. The loaded configuration is start pixel 3, width 16, falling-edge sync reference, internal source and averaging enabled.
- R2: `cfg_sync_lead`=0 restarts the pixel count on a falling edge of `hsync_in` and `cfg_sync_lead`=1 restarts it on a rising edge. In internal mode, `clamp_out` rises S+4 clock edges after the edge that first samples the selected transition, where S is the start pixel.
- R3: The start pixel S is the 13-bit value {`cfg_start_hi`[4:0], `cfg_start_lo`[7:0]}.
- R4: With a loaded width W of 2 or more, the internal clamp pulse stays high for exactly W clock cycles, unless R6 cuts it short.
- R5: A loaded width of 0 or 1 produces no clamp pulse and no strobes, and it leaves `ofs_active` unchanged.
- R6: If the next selected sync transition arrives while the pulse is still high, `clamp_out` falls 3 clock edges after the edge that first samples that transition.
- R7: `clamp_lead` is high for exactly the first cycle of each clamp pulse, and never at any other time. `ofs_active` takes the pending value at the same clock edge.
- R8: `ofs_wr` writes `ofs_wdata` into the pending register. `ofs_active` does not change except at a clamp leading edge.
- R9: `avg_start` is high in the same cycle as `clamp_lead` when `cfg_avg_off`=0, and it stays low when `cfg_avg_off`=1.
- R10: `cfg_src`=2'b01 selects the external source. In that mode `clamp_out` follows `ext_clamp_in` two clock edges later and the internal generator is ignored. Every other code selects the internal source, and `ext_clamp_in` is then ignored.
- R11: The configuration inputs take effect only at a clock edge where `cfg_load` is high. At any other time their values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, active high, asynchronous |
| ext_clamp_in | input | 1 | External clamp request, asynchronous |
| cfg_load | input | 1 | Captures all cfg_* fields |
| cfg_sync_lead | input | 1 | 1: count from rising sync edge, 0: from falling |
| cfg_avg_off | input | 1 | 1: suppress the averaging start strobe |
| cfg_src | input | 2 | Clamp source, 2'b01 external, others internal |
| cfg_start_hi | input | 5 | Upper part of the start pixel |
| cfg_start_lo | input | 8 | Lower part of the start pixel |
| cfg_width | input | 8 | Clamp width in pixels |
| ofs_wr | input | 1 | Write strobe for the pending offset |
| ofs_wdata | input | 8 | Pending offset value |
| clamp_out | output | 1 | Clamp pulse |
| clamp_lead | output | 1 | One-cycle strobe at the clamp leading edge |
| avg_start | output | 1 | Black-level averaging start strobe |
| ofs_active | output | 8 | Committed offset value |

## Verification
The internal generator is tested with sync lines referenced to each edge polarity, with start pixels below and above 255, and with widths of 2, 5, 8 and 16. The expected rise cycles show whether the edge selection and the 13-bit start assembly are right. Widths of 0 and 1 check that the pulse is suppressed and that no offset is committed. A long pulse followed by an early sync edge checks truncation, and the same setting on an unfollowed line checks the full width. External pulses are driven under source code 01 and under source code 10, and sync lines are driven in external mode. Together these show that each source ignores the other and that offsets commit only at an external leading edge.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_RSV2 = 2'b10,
        SRC_RSV3 = 2'b11
    } lcg_src_e;

    localparam int LCG_DEF_START = 3;
    localparam int LCG_DEF_WIDTH = 16;
    localparam int LCG_MIN_WIDTH = 2;

endpackage

// File: rtl/lcg_sync.sv
module lcg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] stage_d, stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = d_in;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/lcg_line_counter.sv
module lcg_line_counter #(
    parameter int POS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_sync,
    input  logic             sync_lead,
    input  logic [POS_W-1:0] start,
    output logic             line_edge,
    output logic             hit
);

    localparam logic [POS_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [POS_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        line_edge = sync_lead ? (hs_sync & ~st_q.prev) : (~hs_sync & st_q.prev);
        hit       = st_q.armed && (st_q.cnt == start) && !line_edge;
        st_d.prev = hs_sync;
        if (line_edge) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            if (hit) st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcg_pulse_shaper.sv
module lcg_pulse_shaper
    import lcg_pkg::*;
#(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             line_edge,
    input  logic [WID_W-1:0] width,
    output logic             pulse
);

    localparam logic [WID_W-1:0] MIN_W = WID_W'(LCG_MIN_WIDTH);

    typedef struct packed {
        logic             active;
        logic [WID_W-1:0] rem;
    } shp_st_t;

    shp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_edge) begin
            st_d.active = 1'b0;
            st_d.rem    = '0;
        end else if (hit && (width >= MIN_W)) begin
            st_d.active = 1'b1;
            st_d.rem    = width;
        end else if (st_q.active) begin
            if (st_q.rem == WID_W'(1)) st_d.active = 1'b0;
            st_d.rem = st_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.active;

endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
    import lcg_pkg::*;
#(
    parameter int POS_W       = 13,
    parameter int LO_W        = 8,
    parameter int WID_W       = 8,
    parameter int OFS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hsync_in,
    input  logic                  ext_clamp_in,
    input  logic                  cfg_load,
    input  logic                  cfg_sync_lead,
    input  logic                  cfg_avg_off,
    input  logic [1:0]            cfg_src,
    input  logic [POS_W-LO_W-1:0] cfg_start_hi,
    input  logic [LO_W-1:0]       cfg_start_lo,
    input  logic [WID_W-1:0]      cfg_width,
    input  logic                  ofs_wr,
    input  logic [OFS_W-1:0]      ofs_wdata,
    output logic                  clamp_out,
    output logic                  clamp_lead,
    output logic                  avg_start,
    output logic [OFS_W-1:0]      ofs_active
);

    typedef struct packed {
        logic             sync_lead;
        logic             avg_off;
        logic             ext_sel;
        logic [POS_W-1:0] start;
        logic [WID_W-1:0] width;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [OFS_W-1:0] pend;
        logic [OFS_W-1:0] act;
        logic             clamp;
        logic             lead;
        logic             avg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic hs_s, ex_s, line_edge, hit, int_pulse, clamp_src;
    logic cfg_ext_q;
    logic [WID_W-1:0] cfg_width_q;

    lcg_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (hsync_in),
        .q_out (hs_s)
    );

    lcg_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ext_clamp_in),
        .q_out (ex_s)
    );

    lcg_line_counter #(.POS_W(POS_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_sync   (hs_s),
        .sync_lead (st_q.cfg.sync_lead),
        .start     (st_q.cfg.start),
        .line_edge (line_edge),
        .hit       (hit)
    );

    lcg_pulse_shaper #(.WID_W(WID_W)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .line_edge (line_edge),
        .width     (st_q.cfg.width),
        .pulse     (int_pulse)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.cfg.sync_lead = cfg_sync_lead;
            st_d.cfg.avg_off   = cfg_avg_off;
            st_d.cfg.ext_sel   = (lcg_src_e'(cfg_src) == SRC_EXT);
            st_d.cfg.start     = {cfg_start_hi, cfg_start_lo};
            st_d.cfg.width     = cfg_width;
        end
        clamp_src  = st_q.cfg.ext_sel ? ex_s : int_pulse;
        st_d.clamp = clamp_src;
        st_d.lead  = clamp_src & ~st_q.clamp;
        st_d.avg   = clamp_src & ~st_q.clamp & ~st_q.cfg.avg_off;
        if (ofs_wr) st_d.pend = ofs_wdata;
        if (st_d.lead) st_d.act = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.cfg.start     <= POS_W'(LCG_DEF_START);
            st_q.cfg.width     <= WID_W'(LCG_DEF_WIDTH);
        end else begin
            st_q <= st_d;
        end
    end

    assign clamp_out   = st_q.clamp;
    assign clamp_lead  = st_q.lead;
    assign avg_start   = st_q.avg;
    assign ofs_active  = st_q.act;
    assign cfg_ext_q   = st_q.cfg.ext_sel;
    assign cfg_width_q = st_q.cfg.width;

endmodule

// File: rtl/lcg_checker.sv
module lcg_checker #(
    parameter int WID_W = 8,
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clamp_out,
    input logic             clamp_lead,
    input logic             avg_start,
    input logic [OFS_W-1:0] ofs_active,
    input logic             ext_sel,
    input logic [WID_W-1:0] width_q
);

    a_r7_lead_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_lead |-> (clamp_out && !$past(clamp_out)));

    a_r7_rise_has_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_out) |-> clamp_lead);

    a_r9_avg_with_lead: assert property (@(posedge clk) disable iff (!rst_n)
        avg_start |-> clamp_lead);

    a_r8_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_lead |-> $stable(ofs_active));

    a_r5_narrow_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clamp_out) && !$past(ext_sel)) |-> ($past(width_q, 2) >= WID_W'(2)));

endmodule

bind line_clamp_gen lcg_checker #(.WID_W(WID_W), .OFS_W(OFS_W)) u_lcg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clamp_out  (clamp_out),
    .clamp_lead (clamp_lead),
    .avg_start  (avg_start),
    .ofs_active (ofs_active),
    .ext_sel    (cfg_ext_q),
    .width_q    (cfg_width_q)
);

// File: tb/tb_line_clamp_gen.sv
module tb_line_clamp_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, ext_clamp_in = 1'b0;
    logic       cfg_load = 1'b0, cfg_sync_lead = 1'b0, cfg_avg_off = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic [4:0] cfg_start_hi = '0;
    logic [7:0] cfg_start_lo = '0, cfg_width = '0;
    logic       ofs_wr = 1'b0;
    logic [7:0] ofs_wdata = '0;
    logic       clamp_out, clamp_lead, avg_start;
    logic [7:0] ofs_active;

    always #5 clk = ~clk;

    line_clamp_gen dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
        .cfg_load(cfg_load), .cfg_sync_lead(cfg_sync_lead), .cfg_avg_off(cfg_avg_off),
        .cfg_src(cfg_src), .cfg_start_hi(cfg_start_hi), .cfg_start_lo(cfg_start_lo),
        .cfg_width(cfg_width), .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
        .clamp_out(clamp_out), .clamp_lead(clamp_lead), .avg_start(avg_start),
        .ofs_active(ofs_active)
    );

    typedef struct {
        int    rise;
        int    width;
        int    ofs;
        bit    avg;
        string tag;
        string wtag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    bit m_lead = 0, m_avg_off = 0, m_ext = 0;
    int m_start = 3, m_width = 16, m_pend = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic load_cfg(int start, int width, bit lead, bit avg_off, logic [1:0] src);
        cfg_start_hi  = 5'(start >> 8);
        cfg_start_lo  = 8'(start);
        cfg_width     = 8'(width);
        cfg_sync_lead = lead;
        cfg_avg_off   = avg_off;
        cfg_src       = src;
        cfg_load      = 1'b1;
        @(negedge clk);
        cfg_load      = 1'b0;
        // R11: scrambled fields after the load must have no effect
        cfg_start_hi  = '1;
        cfg_start_lo  = 8'hFF;
        cfg_width     = 8'h00;
        cfg_sync_lead = ~lead;
        cfg_avg_off   = ~avg_off;
        cfg_src       = ~src;
        m_start = start; m_width = width; m_lead = lead; m_avg_off = avg_off;
        m_ext   = (src == 2'b01);
    endtask

    task automatic write_ofs(int v);
        ofs_wr = 1'b1; ofs_wdata = 8'(v);
        @(negedge clk);
        ofs_wr = 1'b0; ofs_wdata = '0;
        m_pend = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_line(string tag, int period, bit followed);
        int   base = cyc + 1;
        int   refc = m_lead ? base : base + 4;
        exp_t e;
        if (!m_ext && m_width >= 2) begin
            e.rise = refc + m_start + 4;
            e.width = m_width;
            e.wtag = "R4";
            if (followed && (e.rise + e.width > refc + period + 3)) begin
                e.width = refc + period + 3 - e.rise;
                e.wtag = "R6";
            end
            e.ofs = m_pend;
            e.avg = !m_avg_off;
            e.tag = tag;
            exp_q.push_back(e);
        end
        hsync_in = 1'b1;
        repeat (4) @(negedge clk);
        hsync_in = 1'b0;
        repeat (period - 4) @(negedge clk);
    endtask

    task automatic ext_pulse(int n);
        exp_t e;
        if (m_ext) begin
            e.rise = cyc + 3; e.width = n; e.ofs = m_pend; e.avg = !m_avg_off;
            e.tag = "R10"; e.wtag = "R10";
            exp_q.push_back(e);
        end
        ext_clamp_in = 1'b1;
        repeat (n) @(negedge clk);
        ext_clamp_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // monitor: pops expected pulses as they appear
    exp_t cur;
    bit   open_p = 0, prev_c = 0;
    int   rise_c = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (clamp_out && !prev_c) begin
                rise_c = cyc;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5/R10 unexpected pulse actual=%0d expected=none", cyc);
                end else begin
                    cur = exp_q.pop_front();
                    open_p = 1;
                    check(cur.tag, "rise cycle", cyc, cur.rise);
                    check("R7", "lead strobe", clamp_lead, 1);
                    check("R9", "avg strobe", avg_start, cur.avg);
                    check("R7", "offset commit", ofs_active, cur.ofs);
                end
            end else if (clamp_lead || avg_start) begin
                checks++; fails++;
                $display("FAIL R7 stray strobe actual=%0d expected=0", {clamp_lead, avg_start});
            end
            if (!clamp_out && prev_c && open_p) begin
                check(cur.wtag, "pulse width", cyc - rise_c, cur.width);
                open_p = 0;
            end
            prev_c = clamp_out;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        check("R1", "clamp_out", clamp_out, 0);
        check("R1", "clamp_lead", clamp_lead, 0);
        check("R1", "avg_start", avg_start, 0);
        check("R1", "ofs_active", ofs_active, 0);
        idle(4);

        // R1: defaults start 3, width 16, falling edge, internal
        sync_line("R1", 64, 0);
        idle(20);

        // R8: pending write does not touch active value
        write_ofs(8'h5A);
        idle(5);
        check("R8", "active before lead", ofs_active, 0);
        load_cfg(20, 5, 0, 0, 2'b00);
        sync_line("R11", 64, 0);
        idle(20);

        // R2: rising-edge reference, R9 averaging off
        load_cfg(10, 8, 1, 1, 2'b00);
        sync_line("R2", 64, 0);
        idle(20);

        // R3: start above 255, minimum width
        load_cfg(300, 2, 0, 0, 2'b00);
        sync_line("R3", 320, 0);
        idle(20);

        // R5: widths 1 and 0 are suppressed
        write_ofs(8'h77);
        load_cfg(12, 1, 0, 0, 2'b00);
        sync_line("R5", 64, 0);
        check("R5", "offset after width 1", ofs_active, 8'h5A);
        load_cfg(12, 0, 0, 0, 2'b00);
        sync_line("R5", 64, 0);
        check("R5", "offset after width 0", ofs_active, 8'h5A);
        idle(20);

        // R6: truncation by next sync edge, then full width
        load_cfg(50, 100, 0, 0, 2'b00);
        sync_line("R6", 80, 1);
        sync_line("R4", 160, 0);
        idle(20);

        // R10: external source
        load_cfg(5, 4, 0, 0, 2'b01);
        sync_line("R10", 64, 0);
        write_ofs(8'h33);
        idle(5);
        check("R8", "active before ext lead", ofs_active, 8'h77);
        ext_pulse(6);
        load_cfg(5, 4, 0, 0, 2'b10);
        ext_pulse(6);
        sync_line("R10", 64, 0);
        idle(30);

        check("R4", "pulses left pending", exp_q.size(), 0);
        check("R4", "pulse left open", open_p, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule